// File: doc/BRIEF.md
# Host I/O Write Capture FIFO

This block watches host I/O writes and records them for later inspection by a local processor. A write aimed at the primary port address is broken into one queue entry per byte lane. Each entry holds the data byte and a tag giving the access length and the lane. A write aimed at the alias address is recorded as a single byte, on a lane chosen by software. The processor drains the queue through a register read port. It can also watch a status word, take a level interrupt when the fill reaches a programmable threshold, and read a snapshot of the most recent byte written.

The host side is a plain write strobe with a full address, whose low two bits give the starting lane, a 2-bit size code and a 32-bit data word. The register side is an eight-entry word-indexed port with a combinational read mux. Reading the data register removes the entry at the head of the queue.

Top module: `hwc_capture`

## Requirements
- R1: A data-register read returns a 16-bit word laid out as follows. Bits 7:0 hold the data byte and bits 9:8 the lane. Bits 11:10 hold the length code (00 single byte, 01 first byte of 16-bit, 10 first byte of 32-bit). Bit 12 is 1 when the word holds a queued entry. Bit 14 is 1 for a primary-port entry and 0 for an alias entry. Bits 15 and 13 are 0.
- R2: A primary write with size code 00 at lane L queues one entry with length 00, lane L, and the byte from data bits 8L+7:8L.
- R3: A primary write with size code 01 (16-bit) or 10 (32-bit) queues its bytes in rising lane order. The first byte carries the size code and the following bytes carry length 00. A 32-bit write at lane 0 reads back tags 0x58, 0x51, 0x52 and 0x53. A 16-bit write at lane 2 reads back tags 0x56 and 0x53.
- R4: When a write starting at lane L would run past lane 3, only lanes L to 3 are queued and the upper bytes are dropped.
- R5: No entry is queued for a primary write while the primary activate bit (register 4, bit 0) is 0. The same holds for a write with size code 11, and for a write to an address whose bits above bit 1 match neither port.
- R6: While the alias activate bit (register 5, bit 0) is 1, a write to the alias address queues exactly one length-00 entry. The entry's lane is the alias lane register (register 6, bits 1:0) and its byte comes from that lane of the write data. No entry is queued while the alias activate bit is 0.
- R7: The threshold code sits in configuration register 0, bits 10:8. Codes 0 to 7 select levels of 1, 4, 8, 16, 20, 24, 28 and 30 entries. Status bit 2 is 1 exactly while the count is at or above the selected level, so raising the code above the count clears it at once.
- R8: The queue holds 32 entries. A write that brings more bytes than there are free slots stores only the bytes that fit, in lane order, and sets status bit 1. Status bit 1 clears on a data-register read or a flush.
- R9: Writing configuration bit 0 as 1 empties the queue and clears status bits 0 to 2. Writing bit 1 as 1 clears the snapshot register (register 7) and leaves the queue as it is.
- R10: Writing configuration bit 31 as 1 returns every register to its reset value: the threshold code, interrupt enable, both activate bits, the alias lane, the snapshot, and the queue and its flags.
- R11: A data-register read removes one entry. On an empty queue it returns 0 and changes nothing. Status bit 0 is 1 exactly while the queue holds an entry.
- R12: The irq output equals status bit 2 AND interrupt enable bit 0 (register 3).
- R13: After any captured write, the snapshot register holds the byte of the highest lane that write produced, even when some of its bytes were dropped for lack of space.
- R14: After reset every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | AW | Host I/O address; bits 1:0 give the starting lane |
| host_size | input | 2 | 00 byte, 01 16-bit, 10 32-bit, 11 invalid |
| host_wdata | input | 32 | Host write data, lane k in bits 8k+7:8k |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the queue at index 2 |
| reg_addr | input | 3 | Register index: 0 config, 1 status, 2 data, 3 irq enable, 4 primary activate, 5 alias activate, 6 alias lane, 7 snapshot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Threshold interrupt, level |

## Verification
Every size code is written at every starting lane that gives a distinct result. This separates aligned splits, splits that lose upper bytes, and the invalid size. Each tag and byte is compared in read-out order, so a wrong length code, a wrong lane order or a wrong byte is caught. A fill sweep from 1 to 32 entries reads the threshold flag under all eight codes at every count, which separates the non-linear level table from off-by-one compares. Directed cases cover a partial fit when the queue has two free slots, the alias lane select, the clear effects of each configuration bit, and the ignored writes.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        LEN_B1  = 2'b00,
        LEN_B2  = 2'b01,
        LEN_B4  = 2'b10,
        LEN_BAD = 2'b11
    } len_e;

    typedef struct packed {
        logic       src_pri;
        len_e       len;
        logic [1:0] lane;
        logic [7:0] data;
    } entry_t;

    typedef enum logic [2:0] {
        RA_CFG   = 3'd0,
        RA_STAT  = 3'd1,
        RA_DATA  = 3'd2,
        RA_IEN   = 3'd3,
        RA_ACT_P = 3'd4,
        RA_ACT_A = 3'd5,
        RA_ALANE = 3'd6,
        RA_SNAP  = 3'd7
    } reg_e;

    localparam int CFG_FLUSH   = 0;
    localparam int CFG_SNAPCLR = 1;
    localparam int CFG_THR_LSB = 8;
    localparam int CFG_SRST    = 31;

    // Non-linear fill level chosen by the 3-bit threshold code
    function automatic logic [5:0] thr_level(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd1;
            3'd1:    return 6'd4;
            3'd2:    return 6'd8;
            3'd3:    return 6'd16;
            3'd4:    return 6'd20;
            3'd5:    return 6'd24;
            3'd6:    return 6'd28;
            default: return 6'd30;
        endcase
    endfunction

    function automatic logic [2:0] len_bytes(input len_e l);
        case (l)
            LEN_B1:  return 3'd1;
            LEN_B2:  return 3'd2;
            LEN_B4:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [15:0] pack_word(input entry_t e);
        return {1'b0, e.src_pri, 1'b0, 1'b1, e.len, e.lane, e.data};
    endfunction

endpackage

// File: rtl/hwc_lane_split.sv
module hwc_lane_split
    import hwc_pkg::*;
(
    input  logic                    hit_pri,
    input  logic                    hit_ali,
    input  len_e                    size,
    input  logic [1:0]              lane,
    input  logic [31:0]             wdata,
    input  logic [1:0]              ali_lane,
    output entry_t [LANES-1:0]      ent,
    output logic [2:0]              n_ent
);

    logic [2:0] want;
    logic [2:0] room;

    assign want = len_bytes(size);
    assign room = 3'(LANES) - {1'b0, lane};

    // Bytes that would pass the top lane are dropped
    always_comb begin
        if (hit_pri)      n_ent = (want < room) ? want : room;
        else if (hit_ali) n_ent = 3'd1;
        else              n_ent = 3'd0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [1:0] ln;
        entry_t     e;
        assign ln = hit_pri ? (lane + 2'(i)) : ali_lane;
        always_comb begin
            e.src_pri = hit_pri;
            e.len     = (hit_pri && i == 0) ? size : LEN_B1;
            e.lane    = ln;
            e.data    = wdata[{ln, 3'b000} +: 8];
        end
        assign ent[i] = e;
    end

endmodule

// File: rtl/hwc_fifo.sv
module hwc_fifo
    import hwc_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [2:0]           push_n,
    input  entry_t [LANES-1:0]   push_ent,
    input  logic                 pop,
    output entry_t               head,
    output logic [CW-1:0]        count,
    output logic                 ovf
);

    entry_t          mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   free;
    logic [CW-1:0]   n_acc;
    logic            do_pop;

    assign free   = CW'(DEPTH) - cnt;
    assign ovf    = CW'(push_n) > free;
    assign n_acc  = ovf ? free : CW'(push_n);
    assign do_pop = pop && (cnt != '0);
    assign head   = mem[rptr];
    assign count  = cnt;

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (CW'(i) < n_acc) mem[wptr + AW'(i)] <= push_ent[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + AW'(n_acc);
            if (do_pop) rptr <= rptr + 1'b1;
            cnt  <= cnt + n_acc - CW'(do_pop);
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0));

    p_pop_step_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt != '0 && push_n == 3'd0 && !flush) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/hwc_capture.sv
module hwc_capture
    import hwc_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [15:0] PRI_BASE = 16'h0080,
    parameter logic [15:0] ALI_BASE = 16'h0090,
    parameter int          DEPTH    = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [AW-1:0]  host_addr,
    input  logic [1:0]     host_size,
    input  logic [31:0]    host_wdata,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [2:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           irq
);

    logic [2:0]          thr_code;
    logic                ien, act_pri, act_ali, ovr;
    logic [1:0]          ali_lane;
    logic [7:0]          snap;

    logic                cfg_wr, srst, do_flush, snap_clr, pop;
    logic                pri_match, ali_match, hit_pri, hit_ali;
    entry_t [LANES-1:0]  ent;
    logic [2:0]          n_ent;
    entry_t              head;
    logic [CW-1:0]       cnt;
    logic [CW-1:0]       thr_cnt;
    logic                ovf, thr_stat, not_empty;

    assign cfg_wr    = reg_wr && (reg_addr == RA_CFG);
    assign srst      = cfg_wr && reg_wdata[CFG_SRST];
    assign do_flush  = srst || (cfg_wr && reg_wdata[CFG_FLUSH]);
    assign snap_clr  = cfg_wr && reg_wdata[CFG_SNAPCLR];
    assign pop       = reg_rd && (reg_addr == RA_DATA);

    assign pri_match = host_addr[AW-1:2] == PRI_BASE[AW-1:2];
    assign ali_match = host_addr[AW-1:2] == ALI_BASE[AW-1:2];
    assign hit_pri   = host_wr && act_pri && pri_match;
    assign hit_ali   = host_wr && act_ali && ali_match && !pri_match;

    hwc_lane_split u_split (
        .hit_pri  (hit_pri),
        .hit_ali  (hit_ali),
        .size     (len_e'(host_size)),
        .lane     (host_addr[1:0]),
        .wdata    (host_wdata),
        .ali_lane (ali_lane),
        .ent      (ent),
        .n_ent    (n_ent)
    );

    hwc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (do_flush),
        .push_n   (n_ent),
        .push_ent (ent),
        .pop      (pop),
        .head     (head),
        .count    (cnt),
        .ovf      (ovf)
    );

    assign thr_cnt   = CW'(thr_level(thr_code));
    assign not_empty = cnt != '0;
    assign thr_stat  = cnt >= thr_cnt;
    assign irq       = thr_stat && ien;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            thr_code <= '0;
            ien      <= 1'b0;
            act_pri  <= 1'b0;
            act_ali  <= 1'b0;
            ali_lane <= '0;
            ovr      <= 1'b0;
            snap     <= '0;
        end else begin
            if (cfg_wr) thr_code <= reg_wdata[CFG_THR_LSB +: 3];
            if (reg_wr && reg_addr == RA_IEN)   ien      <= reg_wdata[0];
            if (reg_wr && reg_addr == RA_ACT_P) act_pri  <= reg_wdata[0];
            if (reg_wr && reg_addr == RA_ACT_A) act_ali  <= reg_wdata[0];
            if (reg_wr && reg_addr == RA_ALANE) ali_lane <= reg_wdata[1:0];

            if (do_flush)  ovr <= 1'b0;
            else if (ovf)  ovr <= 1'b1;
            else if (pop)  ovr <= 1'b0;

            if (snap_clr)              snap <= '0;
            else if (n_ent != 3'd0)    snap <= ent[2'(n_ent - 3'd1)].data;
        end
    end

    always_comb begin
        case (reg_e'(reg_addr))
            RA_CFG:   reg_rdata = {21'b0, thr_code, 8'b0};
            RA_STAT:  reg_rdata = {29'b0, thr_stat, ovr, not_empty};
            RA_DATA:  reg_rdata = not_empty ? {16'b0, pack_word(head)} : 32'b0;
            RA_IEN:   reg_rdata = {31'b0, ien};
            RA_ACT_P: reg_rdata = {31'b0, act_pri};
            RA_ACT_A: reg_rdata = {31'b0, act_ali};
            RA_ALANE: reg_rdata = {30'b0, ali_lane};
            default:  reg_rdata = {24'b0, snap};
        endcase
    end

    p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf && !do_flush) |=> ovr);

    p_trunc_r4: assert property (@(posedge clk) disable iff (rst)
        hit_pri |-> (({1'b0, n_ent} + {2'b0, host_addr[1:0]}) <= 4'd4));

    p_full_word_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_pri && host_size == 2'b10 && host_addr[1:0] == 2'b00) |-> (n_ent == 3'd4));

    p_srst_r10: assert property (@(posedge clk) disable iff (rst)
        srst |=> (thr_code == 3'd0 && !ien && !act_pri && !act_ali && cnt == '0));

    p_empty_rd_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt == '0 && n_ent == 3'd0 && !do_flush) |=> (cnt == '0));

endmodule

// File: tb/hwc_capture_tb.sv
module hwc_capture_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] PRI = 16'h0080;
    localparam logic [15:0] ALI = 16'h0090;
    localparam logic [31:0] WD  = 32'h4433_2211;
    localparam int          THR [8] = '{1, 4, 8, 16, 20, 24, 28, 30};

    typedef struct packed {
        logic [1:0]  lane;
        logic [1:0]  size;
        logic [2:0]  n;
        logic [31:0] tags;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'd0, 2'd0, 3'd1, 32'h5000_0000},
        '{2'd2, 2'd0, 3'd1, 32'h5200_0000},
        '{2'd0, 2'd1, 3'd2, 32'h5451_0000},
        '{2'd2, 2'd1, 3'd2, 32'h5653_0000},
        '{2'd0, 2'd2, 3'd4, 32'h5851_5253},
        '{2'd1, 2'd2, 3'd3, 32'h5952_5300},
        '{2'd3, 2'd1, 3'd1, 32'h5700_0000},
        '{2'd3, 2'd2, 3'd1, 32'h5B00_0000},
        '{2'd1, 2'd1, 3'd2, 32'h5552_0000},
        '{2'd0, 2'd3, 3'd0, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hwc_capture u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_w(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_size = sz; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_w(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_r(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  last_snap;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R14 reset state
        reg_r(3'd0, rd); chk("R14 cfg", rd, 32'h0);
        reg_r(3'd1, rd); chk("R14 status", rd, 32'h0);
        reg_r(3'd4, rd); chk("R14 primary activate", rd, 32'h0);
        reg_r(3'd7, rd); chk("R14 snapshot", rd, 32'h0);
        chk("R14 irq", {31'b0, irq}, 32'h0);
        reg_r(3'd2, rd); chk("R11 empty read", rd, 32'h0);

        // R5 primary inactive
        host_w(PRI, 2'd2, WD);
        reg_r(3'd1, rd); chk("R5 inactive primary", rd, 32'h0);

        reg_w(3'd4, 32'h1);
        // R5 foreign address
        host_w(16'h00A0, 2'd2, WD);
        reg_r(3'd1, rd); chk("R5 foreign address", rd, 32'h0);

        // Vector table: splitting, tags and snapshot
        last_snap = 8'h00;
        for (int v = 0; v < 10; v++) begin
            string req;
            logic [7:0] tg;
            logic [7:0] by;
            if (VECS[v].n == 3'd0)                     req = "R5 size11";
            else if (VECS[v].size == 2'd0)             req = "R2";
            else if (32'(VECS[v].lane) + (VECS[v].size == 2'd1 ? 2 : 4) > 4) req = "R4";
            else                                       req = "R3";
            host_w(PRI | {14'b0, VECS[v].lane}, VECS[v].size, WD);
            reg_r(3'd1, rd);
            chk({req, " status"}, rd, (VECS[v].n != 0) ? 32'h5 : 32'h0);
            for (int j = 0; j < 4; j++) begin
                if (j < int'(VECS[v].n)) begin
                    tg = VECS[v].tags[31 - 8*j -: 8];
                    by = WD[8*tg[1:0] +: 8];
                    last_snap = by;
                    reg_r(3'd2, rd);
                    chk({req, " R1 word"}, rd, {16'b0, tg, by});
                end
            end
            reg_r(3'd7, rd); chk("R13 snapshot", rd, {24'b0, last_snap});
            reg_r(3'd2, rd); chk("R11 drained", rd, 32'h0);
        end

        // R9 snapshot clear leaves queue
        host_w(PRI, 2'd0, WD);
        reg_w(3'd0, 32'h2);
        reg_r(3'd7, rd); chk("R9 snapshot clear", rd, 32'h0);
        reg_r(3'd1, rd); chk("R9 queue kept", rd, 32'h5);
        // R9 flush
        host_w(PRI, 2'd2, WD);
        reg_w(3'd0, 32'h1);
        reg_r(3'd1, rd); chk("R9 flush status", rd, 32'h0);
        reg_r(3'd2, rd); chk("R9 flush data", rd, 32'h0);

        // R6 alias
        host_w(ALI, 2'd0, 32'hAABB_CCDD);
        reg_r(3'd1, rd); chk("R6 alias inactive", rd, 32'h0);
        reg_w(3'd5, 32'h1);
        reg_w(3'd6, 32'h2);
        host_w(ALI, 2'd2, 32'hAABB_CCDD);
        reg_r(3'd2, rd); chk("R6 alias lane2", rd, 32'h0000_12BB);
        reg_r(3'd2, rd); chk("R6 alias single", rd, 32'h0);
        reg_w(3'd6, 32'h3);
        host_w(ALI | 16'h1, 2'd0, 32'hAABB_CCDD);
        reg_r(3'd2, rd); chk("R6 alias lane3", rd, 32'h0000_13AA);

        // R7 sweep over count and code
        for (int c = 1; c <= 32; c++) begin
            host_w(PRI, 2'd0, 32'(c));
            for (int k = 0; k < 8; k++) begin
                reg_w(3'd0, 32'(k) << 8);
                reg_r(3'd1, rd);
                chk("R7 threshold", rd, {29'b0, (c >= THR[k]), 1'b0, 1'b1});
            end
        end
        // R8 full queue write
        host_w(PRI, 2'd1, WD);
        reg_r(3'd1, rd); chk("R8 overrun full", rd, 32'h7);
        for (int i = 1; i <= 32; i++) begin
            reg_r(3'd2, rd);
            chk("R8 contents", rd, {16'b0, 8'h50, 8'(i)});
            if (i == 1) begin
                reg_r(3'd1, rd); chk("R8 read clears", rd, 32'h5);
            end
        end
        reg_r(3'd2, rd); chk("R8 no extra", rd, 32'h0);

        // R8 partial fit
        reg_w(3'd0, 32'h1);
        for (int i = 1; i <= 30; i++) host_w(PRI, 2'd0, 32'(i));
        host_w(PRI, 2'd2, WD);
        reg_r(3'd1, rd); chk("R8 partial overrun", rd, 32'h7);
        reg_r(3'd7, rd); chk("R13 snapshot on overrun", rd, 32'h44);
        for (int i = 1; i <= 30; i++) reg_r(3'd2, rd);
        reg_r(3'd2, rd); chk("R8 fit first", rd, 32'h0000_5811);
        reg_r(3'd2, rd); chk("R8 fit second", rd, 32'h0000_5122);
        reg_r(3'd2, rd); chk("R8 dropped", rd, 32'h0);
        reg_r(3'd1, rd); chk("R8 cleared", rd, 32'h0);

        // R12 interrupt gating
        reg_w(3'd3, 32'h1);
        reg_w(3'd0, 32'h100);
        for (int i = 0; i < 3; i++) host_w(PRI, 2'd0, WD);
        chk("R12 below level", {31'b0, irq}, 32'h0);
        host_w(PRI, 2'd0, WD);
        chk("R12 at level", {31'b0, irq}, 32'h1);
        reg_w(3'd3, 32'h0);
        chk("R12 disabled", {31'b0, irq}, 32'h0);
        reg_w(3'd3, 32'h1);
        reg_w(3'd0, 32'h200);
        chk("R7 raised code", {31'b0, irq}, 32'h0);
        reg_r(3'd1, rd); chk("R7 raised status", rd, 32'h1);

        // R10 soft reset
        reg_w(3'd0, 32'h300);
        reg_w(3'd6, 32'h1);
        reg_w(3'd0, 32'h8000_0000);
        reg_r(3'd0, rd); chk("R10 cfg", rd, 32'h0);
        reg_r(3'd1, rd); chk("R10 status", rd, 32'h0);
        reg_r(3'd3, rd); chk("R10 ien", rd, 32'h0);
        reg_r(3'd4, rd); chk("R10 primary act", rd, 32'h0);
        reg_r(3'd5, rd); chk("R10 alias act", rd, 32'h0);
        reg_r(3'd6, rd); chk("R10 alias lane", rd, 32'h0);
        reg_r(3'd7, rd); chk("R10 snapshot", rd, 32'h0);
        host_w(PRI, 2'd0, WD);
        reg_r(3'd1, rd); chk("R10 deactivated", rd, 32'h0);

        finish_run();
    end

endmodule